// File: doc/BRIEF.md
# SPI Bit-Rate Divisor Solver

This block turns a reference clock frequency and a wanted serial bit rate into a divisor setting for a serial peripheral clock generator. The generated clock is the reference divided first by a power-of-two prescaler of 2, 4, 8 or 16 (selected by a 2-bit exponent field), and then by twice the value of a 6-bit baud field plus one. The exponent comes first in the prescaler chain. Given both rates as unsigned integers, the block chooses a setting. It tries the smallest prescaler first and moves to the next larger one only when the baud field would not fit. A request that cannot be met is pinned to the nearest end of the legal range and flagged.

A request enters through a valid/ready handshake. The block takes one request at a time. While it works on a request, `req_ready` stays low, and a waiting `req_valid` with its operands must be held until it is accepted. The block divides the reference rate by the wanted rate once, using a serial restoring divider that produces one quotient bit per cycle. It then scans the prescaler stages, one per cycle, by shifting that quotient. The finished setting, its clamp flags and a one-cycle `done` pulse appear together. All of them hold their values until the next accepted request completes. A requested rate of zero is rejected with an error and no division takes place.

Top module: `spi_rate_solver`

## Requirements
- R1: `req_ready` is high exactly when the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. After a request with a nonzero rate is taken, `busy` is high and `req_ready` is low until the result is delivered.
- R2: With base = floor(mainclk / speed), the result for exponent d is q(d) = floor(base / (4·2^d)). The block picks the first d in the order 0, 1, 2, 3 for which 5 ≤ q(d) ≤ 64, and outputs cfg = {d, q(d) − 1}. The exponent sits in cfg[7:6] and the baud field in cfg[5:0]. Both clamp flags are low.
- R3: If q(d) < 5 at the stage being examined, the rate is too high. The result is cfg = {d, 4} with `clamp_high` set and `clamp_low` clear.
- R4: If no stage fits, the rate is too low. The result is cfg = {3, 63} with `clamp_low` set and `clamp_high` clear.
- R5: A request with speed = 0 yields `err` = 1, cfg = 0 and both clamp flags low, delivered with `done` on the cycle after acceptance. `busy` never rises for it.
- R6: `done` is a one-cycle pulse, one per accepted request. It arrives together with the new result and while `busy` is low.
- R7: cfg and the flags change only on a cycle where `done` is high. Otherwise they keep their value, including while a later request is being worked on.
- R8: Whenever `err` is low after a completion, the baud field lies in 4..63, and the two clamp flags are never high together.
- R9: At the edges of the achievable range, a rate of exactly mainclk/20 gives {0, 4} with no clamp. A rate of mainclk/(16·128+1)+1 gives {3, 63} with no clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request operands are valid |
| req_ready | output | 1 | Block can take a request |
| mainclk | input | 32 | Reference clock frequency, unsigned integer |
| speed | input | 32 | Wanted bit rate, unsigned integer |
| busy | output | 1 | Division or stage scan in progress |
| done | output | 1 | One-cycle pulse: new result valid |
| cfg | output | 8 | {exponent[1:0], baud[5:0]} |
| clamp_high | output | 1 | Rate was above the achievable maximum |
| clamp_low | output | 1 | Rate was below the achievable minimum |
| err | output | 1 | Rate of zero was requested |

## Verification
The main function is driven with several kinds of rate:
- Rates whose fitting exponent is 0, 1 and 2. These separate a correct first-fit scan from one that stops early or late.
- Rates one step on each side of both range limits. These show the clamp decision against the exact floor arithmetic rather than the nominal limits.
- Extreme operands: a full-scale reference with a tiny rate, and a rate equal to the reference. These test the divider's full 32-bit width.
- A zero rate, which checks the error path and that no division is started.
- Random reference/rate pairs, compared against an independent floor-division model.

Requests are also presented while the block is busy, to check the back-pressure rule and that the previous result stays stable.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DIVIDE = 2'd1,
    ST_SCAN   = 2'd2
  } solver_state_t;

endpackage

// File: rtl/spi_rate_divu.sv
module spi_rate_divu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          done_q;
  logic [W:0]    shifted;
  logic [W+1:0]  diff;
  logic          borrow;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, den};
    borrow  = diff[W+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= num;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (borrow) begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end else begin
          rem_q <= diff[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/spi_rate_stage.sv
module spi_rate_stage #(
  parameter int W       = 32,
  parameter int STAGES  = 4,
  parameter int BRG_MIN = 4,
  parameter int BRG_MAX = 63
) (
  input  logic [W-1:0]                     base,
  input  logic [$clog2(STAGES)-1:0]        stage,
  output logic                             too_fast,
  output logic                             fits,
  output logic [$clog2(BRG_MAX+1)-1:0]     brg_code
);
  localparam int BRG_W = $clog2(BRG_MAX + 1);

  logic [W-1:0] q_arr [STAGES];
  logic [W-1:0] q_sel;
  logic [W-1:0] q_m1;

  for (genvar g = 0; g < STAGES; g++) begin : g_shift
    assign q_arr[g] = base >> (g + 2);
  end

  always_comb begin
    q_sel    = q_arr[stage];
    q_m1     = q_sel - W'(1);
    too_fast = q_sel < W'(BRG_MIN + 1);
    fits     = q_sel <= W'(BRG_MAX + 1);
    brg_code = too_fast ? BRG_W'(BRG_MIN) : q_m1[BRG_W-1:0];
  end
endmodule

// File: rtl/spi_rate_solver.sv
module spi_rate_solver
  import spi_rate_pkg::*;
#(
  parameter int W       = 32,
  parameter int STAGES  = 4,
  parameter int BRG_MIN = 4,
  parameter int BRG_MAX = 63
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              req_valid,
  output logic                                              req_ready,
  input  logic [W-1:0]                                      mainclk,
  input  logic [W-1:0]                                      speed,
  output logic                                              busy,
  output logic                                              done,
  output logic [$clog2(STAGES)+$clog2(BRG_MAX+1)-1:0]       cfg,
  output logic                                              clamp_high,
  output logic                                              clamp_low,
  output logic                                              err
);
  localparam int SW    = $clog2(STAGES);
  localparam int BRG_W = $clog2(BRG_MAX + 1);
  localparam int CFG_W = SW + BRG_W;

  solver_state_t state_q;
  logic [W-1:0]     m_q, s_q;
  logic [SW-1:0]    stage_q;
  logic             div_start_q;
  logic [CFG_W-1:0] cfg_q;
  logic             ch_q, cl_q, err_q, done_q;
  logic             div_done;
  logic [W-1:0]     base;
  logic             too_fast, fits;
  logic [BRG_W-1:0] brg_code;
  logic             accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  spi_rate_divu #(.W(W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start_q),
    .num   (m_q),
    .den   (s_q),
    .done  (div_done),
    .quo   (base)
  );

  spi_rate_stage #(.W(W), .STAGES(STAGES), .BRG_MIN(BRG_MIN), .BRG_MAX(BRG_MAX)) u_stage (
    .base     (base),
    .stage    (stage_q),
    .too_fast (too_fast),
    .fits     (fits),
    .brg_code (brg_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      m_q         <= '0;
      s_q         <= '0;
      stage_q     <= '0;
      div_start_q <= 1'b0;
      cfg_q       <= '0;
      ch_q        <= 1'b0;
      cl_q        <= 1'b0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      div_start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (speed == '0) begin
              cfg_q  <= '0;
              ch_q   <= 1'b0;
              cl_q   <= 1'b0;
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              m_q         <= mainclk;
              s_q         <= speed;
              div_start_q <= 1'b1;
              state_q     <= ST_DIVIDE;
            end
          end
        end
        ST_DIVIDE: begin
          if (div_done) begin
            stage_q <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (too_fast || fits) begin
            cfg_q   <= {stage_q, brg_code};
            ch_q    <= too_fast;
            cl_q    <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (stage_q == SW'(STAGES - 1)) begin
            cfg_q   <= {SW'(STAGES - 1), BRG_W'(BRG_MAX)};
            ch_q    <= 1'b0;
            cl_q    <= 1'b1;
            err_q   <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            stage_q <= stage_q + SW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign cfg        = cfg_q;
  assign clamp_high = ch_q;
  assign clamp_low  = cl_q;
  assign err        = err_q;
endmodule

// File: rtl/spi_rate_solver_chk.sv
module spi_rate_solver_chk #(
  parameter int W       = 32,
  parameter int STAGES  = 4,
  parameter int BRG_MIN = 4,
  parameter int BRG_MAX = 63
) (
  input logic                                        clk,
  input logic                                        rst_n,
  input logic                                        req_valid,
  input logic                                        req_ready,
  input logic                                        busy,
  input logic                                        done,
  input logic [$clog2(STAGES)+$clog2(BRG_MAX+1)-1:0] cfg,
  input logic                                        clamp_high,
  input logic                                        clamp_low,
  input logic                                        err
);
  localparam int SW    = $clog2(STAGES);
  localparam int BRG_W = $clog2(BRG_MAX + 1);

  // R1: busy can only start from an accepted request
  assert_busy_from_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

  // R1: no acceptance while working
  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // R3: high clamp pins baud to its minimum
  assert_clamp_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_high |-> (cfg[BRG_W-1:0] == BRG_W'(BRG_MIN)));

  // R4: low clamp pins both fields to their maximum
  assert_clamp_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_low |-> (cfg == {SW'(STAGES - 1), BRG_W'(BRG_MAX)}));

  // R5: error result carries nothing else
  assert_err_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!clamp_high && !clamp_low && cfg == '0));

  // R6: done is a single pulse outside busy
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: outputs hold while working unless the result lands
  assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(cfg) && $stable(clamp_high) && $stable(clamp_low) && $stable(err)) || done);

  // R7: outputs hold while idle without a request
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(req_valid && req_ready)) |=> $stable(cfg) && $stable(err));

  // R8: legal baud field and exclusive clamps
  assert_brg_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (cfg[BRG_W-1:0] >= BRG_W'(BRG_MIN)) && !(clamp_high && clamp_low));
endmodule

bind spi_rate_solver spi_rate_solver_chk #(
  .W(W), .STAGES(STAGES), .BRG_MIN(BRG_MIN), .BRG_MAX(BRG_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .done       (done),
  .cfg        (cfg),
  .clamp_high (clamp_high),
  .clamp_low  (clamp_low),
  .err        (err)
);

// File: tb/sim_spi_rate_solver.sv
`timescale 1ns/1ps
module sim_spi_rate_solver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] mainclk = '0;
  logic [31:0] speed = '0;
  logic        busy, done;
  logic [7:0]  cfg;
  logic        clamp_high, clamp_low, err;

  always #4 clk = ~clk;

  spi_rate_solver u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mainclk(mainclk), .speed(speed), .busy(busy), .done(done), .cfg(cfg),
    .clamp_high(clamp_high), .clamp_low(clamp_low), .err(err)
  );

  typedef struct packed {
    logic [7:0] cfg;
    logic       ch;
    logic       cl;
    logic       er;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // independent model: plain floor divisions, first fit over exponents
  function automatic exp_t model(input logic [31:0] m, input logic [31:0] s);
    exp_t e;
    int unsigned base, q;
    e = '0;
    if (s == 0) begin
      e.er = 1'b1;
      return e;
    end
    base = m / s;
    for (int d = 0; d < 4; d++) begin
      q = base / (4 << d);
      if (q < 5) begin
        e.cfg = {2'(d), 6'd4};
        e.ch = 1'b1;
        return e;
      end
      if (q <= 64) begin
        e.cfg = {2'(d), 6'(q - 1)};
        return e;
      end
    end
    e.cfg = {2'd3, 6'd63};
    e.cl = 1'b1;
    return e;
  endfunction

  task automatic send(input logic [31:0] m, input logic [31:0] s);
    exp_q.push_back(model(m, s));
    @(negedge clk);
    req_valid = 1'b1;
    mainclk = m;
    speed = s;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (s != 0) begin
      chk(busy && !req_ready, "R1 busy after accept", {busy, req_ready}, 2'b10);
    end else begin
      chk(!busy, "R5 no busy on zero rate", busy, 0);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(cfg == e.cfg, "R2/R3/R4 cfg", cfg, e.cfg);
        chk({clamp_high, clamp_low, err} == {e.ch, e.cl, e.er}, "R3/R4/R5 flags",
            {clamp_high, clamp_low, err}, {e.ch, e.cl, e.er});
        chk(!busy, "R6 done while idle", busy, 0);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] snap;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && !done, "R1 reset idle", {req_ready, busy, done}, 3'b100);
    chk(cfg == 0 && !clamp_high && !clamp_low && !err, "R7 reset outputs", cfg, 0);

    send(100_000_000, 1_000_000);   // R2 exponent 0
    send(100_000_000, 200_000);     // R2 exponent 1
    send(100_000_000, 100_000);     // R2 exponent 2
    send(100_000_000, 5_000_000);   // R9 exact maximum
    send(100_000_000, 5_000_001);   // R3 just above maximum
    send(100_000_000, 48_805);      // R9 nominal minimum
    send(100_000_000, 48_076);      // R4 below minimum
    send(100_000_000, 100_000_000); // R3 rate equals reference
    send(32'hFFFF_FFFF, 3);         // R4 full-scale operands
    send(48_000_000, 12_000);       // R4
    send(100_000_000, 0);           // R5 zero rate
    send(100_000_000, 0);           // R5 back to back
    send(100_000_000, 1);           // R4 minimal rate

    // R7: result holds while idle and during a following job
    wait (exp_q.size() == 0 && !busy);
    repeat (5) @(negedge clk);
    snap = cfg;
    chk(cfg == snap && !done, "R7 idle hold", cfg, snap);
    send(50_000_000, 400_000);
    chk(cfg == snap, "R7 hold while busy", cfg, snap);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] m, s;
      m = $urandom;
      s = ($urandom % 2_000_000) + 1;
      send(m, s);                   // R2/R3/R4/R8 random
    end

    wait (exp_q.size() == 0 && !busy);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 one done per request", exp_q.size(), 0);
    finish_run();
  end
endmodule